// File: doc/BRIEF.md
# Shared-Timer Input Debouncer

This unit cleans up a bank of 32 asynchronous input pins. Each raw pin first passes through a two-flop synchronizer. It then goes to its own filter, which accepts a new level only after that level has held steadily for a programmed number of clock cycles. The block does not store a period per pin. Instead it keeps a pool of three period registers, and every pin picks one of them with a 2-bit index. Index 0 turns filtering off for that pin.

The index of each pin is split across two select words. The select-high word holds the upper index bit and the select-low word holds the lower one, both at the pin's bit position. Software writes the two select words and the three period words through a small write-only port. Any number of pins may share one period register. A period can be rewritten without touching any selector. Because software rounds its cycle count upward, a filtered edge never comes early.

Top module: `shared_debounce`

## Requirements
- R1: After reset every filtered output is 0, and all periods and selectors are 0, so each pin starts unfiltered.
- R2: An unfiltered pin (index 0) shows a raw change on its filtered output 3 rising edges after the change: 2 synchronizer edges plus 1.
- R3: A pin's index is {select-high bit i, select-low bit i}. Index k (1..3) uses period register k. Writes go to address 0 (select-high), 1 (select-low), 2 (period 1), 3 (period 2) and 4 (period 3), and take effect at the clock edge on which cfg_we is sampled high.
- R4: With a selected period P ≥ 1, a held raw change reaches the filtered output exactly 2+P rising edges after the change.
- R5: A synchronized level that differs from the filtered output for fewer than P consecutive cycles leaves the output unchanged. A return to the filtered level restarts the count from zero.
- R6: A selected period of 0 behaves like index 0 (latency 3 edges).
- R7: Pins that share one period register keep independent counts, so each pin changes 2+P edges after its own raw change.
- R8: Rewriting a period register changes the latency of every pin that selects it, without any selector write.
- R9: Writes with cfg_addr 5, 6 or 7 change no period and no selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| pin_raw | input | 32 | Raw asynchronous pin levels |
| pin_filt | output | 32 | Debounced pin levels |

## Verification
The assertions take for granted that the raw pins feed only the synchronizer. They therefore judge the filter against its synchronized view, never against pin_raw directly. They also assume that a configuration write becomes visible only on the edge after it is sampled. To stay within these assumptions, the stimulus changes pins and configuration only on falling edges. Random periods are kept small (0 to 7), so that pins frequently complete, abort and restart their counts. Period rewrites also land in the middle of a count, which exercises a count that is already above a newly shortened period.

// File: rtl/dbn_pkg.sv
package dbn_pkg;
  // width of a pin's timer index; value 0 means unfiltered
  localparam int IDX_W      = 2;
  localparam int NUM_TIMERS = (1 << IDX_W) - 1;
  localparam int ADDR_W     = 3;

  localparam logic [ADDR_W-1:0] ADDR_SEL_HI   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_SEL_LO   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_TMR_BASE = 3'd2;

  // index assembled from the two select words at one bit position
  function automatic logic [IDX_W-1:0] timer_index(input logic hi, input logic lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/dbn_sync.sv
module dbn_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/dbn_cfg_regs.sv
module dbn_cfg_regs
  import dbn_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int PERIOD_W = 32,
  parameter int DATA_W   = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [ADDR_W-1:0]                    cfg_addr,
  input  logic [DATA_W-1:0]                    cfg_wdata,
  output logic [NUM_PINS-1:0]                  sel_hi,
  output logic [NUM_PINS-1:0]                  sel_lo,
  output logic [NUM_TIMERS-1:0][PERIOD_W-1:0]  tmr_period
);
  logic wr_hi, wr_lo;
  assign wr_hi = cfg_we && (cfg_addr == ADDR_SEL_HI);
  assign wr_lo = cfg_we && (cfg_addr == ADDR_SEL_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_hi <= '0;
    else if (wr_hi) sel_hi <= cfg_wdata[NUM_PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_lo <= '0;
    else if (wr_lo) sel_lo <= cfg_wdata[NUM_PINS-1:0];
  end

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    logic wr_t;
    assign wr_t = cfg_we && (cfg_addr == ADDR_TMR_BASE + ADDR_W'(t));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tmr_period[t] <= '0;
      else if (wr_t) tmr_period[t] <= cfg_wdata[PERIOD_W-1:0];
    end
  end
endmodule

// File: rtl/dbn_pin_filter.sv
module dbn_pin_filter #(
  parameter int PERIOD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_in,
  input  logic [PERIOD_W-1:0] period,
  input  logic                bypass,
  output logic                filt,
  output logic                commit
);
  logic [PERIOD_W-1:0] cnt_q;
  logic                differs;
  logic                reached;

  // true when this cycle completes the run of differing samples
  function automatic logic run_complete(input logic [PERIOD_W-1:0] cnt,
                                        input logic [PERIOD_W-1:0] per);
    logic [PERIOD_W:0] next_len;
    next_len = {1'b0, cnt} + {{PERIOD_W{1'b0}}, 1'b1};
    return next_len >= {1'b0, per};
  endfunction

  assign differs = sync_in ^ filt;
  assign reached = run_complete(cnt_q, period);
  assign commit  = differs && (bypass || reached);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt  <= 1'b0;
      cnt_q <= '0;
    end else if (bypass) begin
      filt  <= sync_in;
      cnt_q <= '0;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (reached) begin
      filt  <= sync_in;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + {{(PERIOD_W-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/shared_debounce.sv
module shared_debounce
  import dbn_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int PERIOD_W    = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  input  logic [NUM_PINS-1:0] pin_raw,
  output logic [NUM_PINS-1:0] pin_filt
);
  logic [NUM_PINS-1:0]                 sel_hi, sel_lo;
  logic [NUM_TIMERS-1:0][PERIOD_W-1:0] tmr_period;
  logic [NUM_PINS-1:0]                 sync_w;
  logic [NUM_PINS-1:0]                 bypass_w;
  logic [NUM_PINS-1:0]                 commit_w;

  function automatic logic [PERIOD_W-1:0] pick_period(
    input logic [IDX_W-1:0]                   idx,
    input logic [NUM_TIMERS-1:0][PERIOD_W-1:0] tm);
    logic [PERIOD_W-1:0] p;
    p = '0;
    for (int t = 1; t <= NUM_TIMERS; t++)
      if (idx == IDX_W'(t)) p = tm[t-1];
    return p;
  endfunction

  dbn_cfg_regs #(
    .NUM_PINS(NUM_PINS), .PERIOD_W(PERIOD_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sel_hi(sel_hi), .sel_lo(sel_lo),
    .tmr_period(tmr_period)
  );

  dbn_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_raw), .d_out(sync_w)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [IDX_W-1:0]    idx_w;
    logic [PERIOD_W-1:0] per_w;
    assign idx_w       = timer_index(sel_hi[i], sel_lo[i]);
    assign per_w       = pick_period(idx_w, tmr_period);
    assign bypass_w[i] = (per_w == '0);

    dbn_pin_filter #(.PERIOD_W(PERIOD_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_w[i]), .period(per_w),
      .bypass(bypass_w[i]), .filt(pin_filt[i]), .commit(commit_w[i])
    );
  end
endmodule

// File: rtl/dbn_checker.sv
module dbn_checker #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] sync_w,
  input logic [NUM_PINS-1:0] bypass_w,
  input logic [NUM_PINS-1:0] commit_w,
  input logic [NUM_PINS-1:0] pin_filt
);
  // R1: outputs held low while reset is applied
  always @(posedge clk)
    if (!rst_n) p_reset_clear_r1: assert (pin_filt == '0)
      else $error("filtered outputs not cleared in reset");

  // R2 and R6: an unfiltered pin copies its synchronized level on the next edge
  p_bypass_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_filt ^ $past(sync_w)) & $past(bypass_w)) == '0);

  // R4: an output may only move on a cycle flagged by its filter
  p_change_needs_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_filt ^ $past(pin_filt)) & ~$past(commit_w)) == '0);

  // R5: agreement between synchronized input and output keeps the output
  p_hold_when_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pin_filt ^ $past(pin_filt)) & ~($past(sync_w) ^ $past(pin_filt))) == '0);
endmodule

bind shared_debounce dbn_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_w(sync_w), .bypass_w(bypass_w),
  .commit_w(commit_w), .pin_filt(pin_filt)
);

// File: tb/shared_debounce_tb.sv
`timescale 1ns/1ps
module shared_debounce_tb;
  localparam int N = 32;
  localparam int SYNC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [N-1:0]  pin_raw = '0;
  logic [N-1:0]  pin_filt;

  int n_checks = 0;
  int n_fail = 0;
  bit model_on = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  shared_debounce u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pin_raw(pin_raw), .pin_filt(pin_filt)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected edges from raw change to filtered change
  function automatic int exp_latency(input int period);
    return SYNC + ((period == 0) ? 1 : period);
  endfunction

  // ---------------- reference model ----------------
  logic [N-1:0] m_s1, m_s2, m_filt, m_hi, m_lo;
  logic [31:0]  m_tmr [3];
  int           m_run [N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_filt = '0; m_hi = '0; m_lo = '0;
      for (int t = 0; t < 3; t++) m_tmr[t] = '0;
      for (int i = 0; i < N; i++) m_run[i] = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        int sel;
        longint per;
        sel = 2 * int'(m_hi[i]) + int'(m_lo[i]);
        per = (sel == 0) ? 0 : longint'(m_tmr[sel-1]);
        if (per == 0) begin
          m_filt[i] = m_s2[i];
          m_run[i] = 0;
        end else if (m_s2[i] == m_filt[i]) begin
          m_run[i] = 0;
        end else if (longint'(m_run[i]) + 1 >= per) begin
          m_filt[i] = m_s2[i];
          m_run[i] = 0;
        end else begin
          m_run[i] = m_run[i] + 1;
        end
      end
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: m_hi = cfg_wdata;
          3'd1: m_lo = cfg_wdata;
          3'd2: m_tmr[0] = cfg_wdata;
          3'd3: m_tmr[1] = cfg_wdata;
          3'd4: m_tmr[2] = cfg_wdata;
          default: ;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = pin_raw;
    end
  end

  always @(negedge clk)
    if (rst_n && model_on && !finished)
      check(pin_filt == m_filt, "R4 model", pin_filt, m_filt);

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic measure(input int pin, input int exp, input string req);
    logic old;
    int n;
    bit seen;
    old = pin_filt[pin];
    n = 0;
    seen = 1'b0;
    @(negedge clk);
    pin_raw[pin] = ~pin_raw[pin];
    for (int k = 0; k < 64 && !seen; k++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (pin_filt[pin] != old) seen = 1'b1;
    end
    check(seen && n == exp, req, n, exp);
    settle();
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check(pin_filt == '0, "R1 reset value", pin_filt, 0);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);
    check(pin_filt == '0, "R1 after reset", pin_filt, 0);

    // R1: default configuration leaves pins unfiltered
    measure(0, exp_latency(0), "R1 default unfiltered");
    measure(0, exp_latency(0), "R1 default unfiltered back");

    wr(3'd2, 32'd5);
    wr(3'd3, 32'd9);
    wr(3'd4, 32'd2);
    wr(3'd0, 32'h0000_0006);   // pins 1,2 high index bit
    wr(3'd1, 32'h0000_0035);   // pins 0,2,4,5 low index bit
    settle();

    measure(0, exp_latency(5), "R4 index1 period5");
    measure(1, exp_latency(9), "R3 index2 uses period 2");
    measure(2, exp_latency(2), "R3 index3 uses period 3");
    measure(3, exp_latency(0), "R2 index0 latency");

    // R5: short pulse away from the filtered level (pin0 filt = 1)
    begin
      bit moved;
      moved = 1'b0;
      @(negedge clk); pin_raw[0] = 1'b0;
      repeat (3) @(negedge clk);
      pin_raw[0] = 1'b1;
      for (int k = 0; k < 15; k++) begin
        @(negedge clk);
        if (pin_filt[0] != 1'b1) moved = 1'b1;
      end
      check(!moved, "R5 glitch rejected", pin_filt[0], 1);
    end
    // R5: count restarts after the input returns
    @(negedge clk); pin_raw[0] = 1'b0;
    repeat (3) @(negedge clk);
    pin_raw[0] = 1'b1;
    @(negedge clk);
    measure(0, exp_latency(5), "R5 restart count");

    // R7: two pins on timer 1 with staggered changes
    begin
      logic o4, o5;
      o4 = pin_filt[4]; o5 = pin_filt[5];
      @(negedge clk); pin_raw[4] = ~pin_raw[4];
      repeat (2) @(negedge clk);
      pin_raw[5] = ~pin_raw[5];
      repeat (exp_latency(5) - 2) @(negedge clk);
      check(pin_filt[4] != o4 && pin_filt[5] == o5, "R7 first pin only",
            {pin_filt[5], pin_filt[4]}, {o5, ~o4});
      repeat (2) @(negedge clk);
      check(pin_filt[5] != o5, "R7 second pin", pin_filt[5], ~o5);
      settle();
    end

    wr(3'd4, 32'd0);
    settle();
    measure(2, exp_latency(0), "R6 zero period bypass");

    wr(3'd2, 32'd3);
    settle();
    measure(0, exp_latency(3), "R8 rewritten period pin0");
    measure(4, exp_latency(3), "R8 rewritten period pin4");

    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'h0000_0000);
    settle();
    measure(0, exp_latency(3), "R9 unused address timer1");
    measure(1, exp_latency(9), "R9 unused address timer2");
    measure(3, exp_latency(0), "R9 unused address select");

    // random phase: model comparison each cycle
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      cfg_we = 1'b0;
      if ($urandom % 40 == 0) begin
        int a;
        a = $urandom % 8;
        cfg_we = 1'b1;
        cfg_addr = 3'(a);
        cfg_wdata = (a >= 2) ? ($urandom % 8) : $urandom;
      end
      pin_raw = pin_raw ^ ($urandom & $urandom & $urandom);
    end
    @(negedge clk);
    cfg_we = 1'b0;
    settle();
    finish_run();
  end
endmodule